// File: doc/BRIEF.md
# Bus Plug-and-Play Descriptor Table

This block is a read-only configuration window of 4 KiB. Software scans it to find the bus masters and bus slaves present on a system on chip. The window holds two lists at fixed places. The master list begins at byte offset 0x000 and the slave list begins at byte offset 0x800. Each list has room for up to `SLOTS` descriptors (64 by default), and each descriptor takes 32 bytes.

Descriptors are not a fixed image. The integration logic supplies them through a registration port. A one-cycle pulse on `reg_valid` appends one descriptor to the list chosen by `reg_is_slave`, in the next free slot of that list. The descriptor is packed from a vendor code, a device code, a base address, an address mask and a type code. A registration on a full list is dropped and reported on `reg_overflow`.

The read side is a simple request/response port. It serves byte, halfword and word reads in big-endian lane order. Bus writes are answered like reads, but they never change the table.

Top module: `pnp_desc_table`

## Requirements
- R1: After reset, every word in the window reads as zero.
- R2: Master registrations fill slots 0, 1, 2, ... in turn, at byte offset 0x000 + 32*n. Slave registrations fill slots in turn at byte offset 0x800 + 32*n. The two fill counts are independent of each other.
- R3: Word 0 of a descriptor (byte offset +0) carries the vendor code in bits 31:24 and the device code in bits 23:12. Bits 11:0 of word 0 are zero.
- R4: Word 4 of a descriptor (byte offset +16) carries these fields:
  - bits 31:20 of the registered base address in bits 31:20;
  - zero in bits 19:16;
  - the 12-bit mask in bits 15:4;
  - the 4-bit type code in bits 3:0.
- R5: Descriptor words 1, 2, 3, 5, 6 and 7 always read as zero, and so do the words of slots that are not yet filled.
- R6: A list holds at most `SLOTS` entries. A registration on a full list has these effects:
  - it stores nothing and leaves that list's count unchanged;
  - it raises `reg_overflow` for exactly the one cycle after the attempt.

  `reg_overflow` is low in every other case.
- R7: `rsp_valid` is high in exactly the cycle after a cycle with `bus_req` high, and low otherwise.
- R8: A byte read (`bus_size`=0) at byte offset b within a word returns bits (31-8b):(24-8b) of that word. The result is placed in rsp_rdata[7:0], and the upper bits are zero.
- R9: A halfword read (`bus_size`=1) returns one half of the word in rsp_rdata[15:0], with the upper bits zero. With `bus_addr[1]`=0 it returns bits 31:16 of the word. With `bus_addr[1]`=1 it returns bits 15:0.
- R10: A word read (`bus_size`=2, or 3) returns the whole word and ignores `bus_addr[1:0]`.
- R11: A write (`bus_we`=1 with `bus_req`) returns zero data and leaves every stored word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, clears table and counts |
| reg_valid | input | 1 | One-cycle registration strobe |
| reg_is_slave | input | 1 | 1 = append to the slave list, 0 = master list |
| reg_vendor | input | 8 | Vendor code of the new descriptor |
| reg_device | input | 12 | Device code of the new descriptor |
| reg_addr | input | 32 | Base address; only bits 31:20 are kept |
| reg_mask | input | 12 | Address mask of the new descriptor |
| reg_type | input | 4 | Type code of the new descriptor |
| reg_overflow | output | 1 | Pulses one cycle after a registration on a full list |
| bus_req | input | 1 | Access request strobe |
| bus_we | input | 1 | 1 = write (ignored), 0 = read |
| bus_addr | input | 12 | Byte offset within the window |
| bus_size | input | 2 | 0 = byte, 1 = halfword, 2 or 3 = word |
| bus_wdata | input | 32 | Write data, discarded |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data, right-aligned and zero-extended |

## Verification
The assertions rely on the following assumptions about the inputs:
- reset is asserted from time zero;
- at most one registration arrives per cycle;
- a halfword access uses an even offset.

Under these assumptions the fill counts can only hold or step by one, and overflow can only follow a registration. The stimulus drives registrations and bus requests in separate cycles, with halfword accesses at offsets 0 and 2 only. It keeps `reg_valid` and `bus_req` high for a single cycle each.

// File: rtl/pnp_pkg.sv
package pnp_pkg;

    // Window geometry: 4 KiB, two lists of 32-byte descriptors.
    localparam int WIN_AW      = 12;
    localparam int SLOT_FLD_W  = 6;   // bus_addr[10:5]
    localparam int WORD_FLD_W  = 3;   // bus_addr[4:2]

    typedef struct packed {
        logic [7:0]  vendor;
        logic [11:0] device;
        logic [11:0] base_hi;
        logic [11:0] mask;
        logic [3:0]  kind;
    } pnp_entry_t;

    typedef struct packed {
        logic        valid;
        logic [31:0] data;
    } pnp_rsp_t;

    function automatic logic [31:0] pack_ident(pnp_entry_t e);
        return {e.vendor, e.device, 12'h000};
    endfunction

    function automatic logic [31:0] pack_bank(pnp_entry_t e);
        return {e.base_hi, 4'h0, e.mask, e.kind};
    endfunction

endpackage

// File: rtl/pnp_fill_ctr.sv
module pnp_fill_ctr #(
    parameter int SLOTS = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_i,
    output logic                       wr_en_o,
    output logic [$clog2(SLOTS)-1:0]   wr_idx_o,
    output logic [$clog2(SLOTS+1)-1:0] fill_o,
    output logic                       ovf_o
);
    localparam int IDX_W = $clog2(SLOTS);
    localparam int CNT_W = $clog2(SLOTS + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(SLOTS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d     = ctr_q;
        ctr_d.ovf = 1'b0;
        wr_en_o   = 1'b0;
        if (push_i) begin
            if (ctr_q.cnt == FULL) begin
                ctr_d.ovf = 1'b1;
            end else begin
                wr_en_o   = 1'b1;
                ctr_d.cnt = ctr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

    assign wr_idx_o = ctr_q.cnt[IDX_W-1:0];
    assign fill_o   = ctr_q.cnt;
    assign ovf_o    = ctr_q.ovf;

endmodule

// File: rtl/pnp_desc_store.sv
module pnp_desc_store
    import pnp_pkg::*;
#(
    parameter int SLOTS = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en_i,
    input  logic [$clog2(SLOTS)-1:0] wr_idx_i,
    input  pnp_entry_t               wr_entry_i,
    input  logic [$clog2(SLOTS)-1:0] rd_idx_i,
    output pnp_entry_t               rd_entry_o
);
    pnp_entry_t mem_q [SLOTS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) mem_q[i] <= '0;
        end else if (wr_en_i) begin
            mem_q[wr_idx_i] <= wr_entry_i;
        end
    end

    assign rd_entry_o = mem_q[rd_idx_i];

endmodule

// File: rtl/pnp_lane_sel.sv
module pnp_lane_sel (
    input  logic [31:0] word_i,
    input  logic [1:0]  offs_i,
    input  logic [1:0]  size_i,
    output logic [31:0] data_o
);
    logic [31:0] shifted;

    always_comb begin
        // big-endian: offset 0 is the most significant byte
        shifted = word_i >> {~offs_i, 3'b000};
        case (size_i)
            2'd0:    data_o = {24'h0, shifted[7:0]};
            2'd1:    data_o = {16'h0, offs_i[1] ? word_i[15:0] : word_i[31:16]};
            default: data_o = word_i;
        endcase
    end

endmodule

// File: rtl/pnp_desc_table.sv
module pnp_desc_table
    import pnp_pkg::*;
#(
    parameter int SLOTS = 64   // 2..64, one window half per list
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_valid,
    input  logic        reg_is_slave,
    input  logic [7:0]  reg_vendor,
    input  logic [11:0] reg_device,
    input  logic [31:0] reg_addr,
    input  logic [11:0] reg_mask,
    input  logic [3:0]  reg_type,
    output logic        reg_overflow,
    input  logic        bus_req,
    input  logic        bus_we,
    input  logic [11:0] bus_addr,
    input  logic [1:0]  bus_size,
    input  logic [31:0] bus_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata
);
    localparam int IDX_W = $clog2(SLOTS);
    localparam int CNT_W = $clog2(SLOTS + 1);

    pnp_entry_t           new_entry;
    logic [1:0]           push, wr_en, ovf;
    logic [IDX_W-1:0]     wr_idx [2];
    logic [CNT_W-1:0]     fill   [2];
    pnp_entry_t           rd_entry [2];
    logic [CNT_W-1:0]     m_cnt, s_cnt;

    logic                  rd_list;
    logic [SLOT_FLD_W-1:0] rd_slot;
    logic [WORD_FLD_W-1:0] rd_word;
    logic [IDX_W-1:0]      rd_idx;
    logic                  slot_ok;
    pnp_entry_t            sel_entry;
    logic [31:0]           word_val, lane_data;
    pnp_rsp_t              rsp_d, rsp_q;
    logic                  unused_sink;

    assign new_entry = '{vendor:  reg_vendor,
                         device:  reg_device,
                         base_hi: reg_addr[31:20],
                         mask:    reg_mask,
                         kind:    reg_type};

    for (genvar g = 0; g < 2; g++) begin : g_list
        assign push[g] = reg_valid && (reg_is_slave == 1'(g));

        pnp_fill_ctr #(.SLOTS(SLOTS)) u_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .push_i   (push[g]),
            .wr_en_o  (wr_en[g]),
            .wr_idx_o (wr_idx[g]),
            .fill_o   (fill[g]),
            .ovf_o    (ovf[g])
        );

        pnp_desc_store #(.SLOTS(SLOTS)) u_store (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en_i    (wr_en[g]),
            .wr_idx_i   (wr_idx[g]),
            .wr_entry_i (new_entry),
            .rd_idx_i   (rd_idx),
            .rd_entry_o (rd_entry[g])
        );
    end

    assign m_cnt        = fill[0];
    assign s_cnt        = fill[1];
    assign reg_overflow = |ovf;

    // window decode: [11] list, [10:5] slot, [4:2] word, [1:0] byte lane
    assign rd_list = bus_addr[WIN_AW-1];
    assign rd_slot = bus_addr[10:5];
    assign rd_word = bus_addr[4:2];
    assign rd_idx  = rd_slot[IDX_W-1:0];
    assign slot_ok = ({26'h0, rd_slot} < 32'(SLOTS));

    always_comb begin
        sel_entry = rd_entry[rd_list];
        word_val  = '0;
        if (slot_ok) begin
            case (rd_word)
                3'd0:    word_val = pack_ident(sel_entry);
                3'd4:    word_val = pack_bank(sel_entry);
                default: word_val = '0;
            endcase
        end
    end

    pnp_lane_sel u_lane (
        .word_i (word_val),
        .offs_i (bus_addr[1:0]),
        .size_i (bus_size),
        .data_o (lane_data)
    );

    always_comb begin
        rsp_d.valid = bus_req;
        rsp_d.data  = (bus_req && !bus_we) ? lane_data : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_rdata = rsp_q.data;

    assign unused_sink = ^{bus_wdata, reg_addr[19:0], m_cnt, s_cnt};

endmodule

// File: rtl/pnp_desc_table_chk.sv
module pnp_desc_table_chk #(
    parameter int SLOTS = 64,
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_valid,
    input logic             reg_overflow,
    input logic             bus_req,
    input logic             bus_we,
    input logic [1:0]       bus_size,
    input logic             rsp_valid,
    input logic [31:0]      rsp_rdata,
    input logic [CNT_W-1:0] m_cnt,
    input logic [CNT_W-1:0] s_cnt
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(SLOTS);

    a_r7_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |=> rsp_valid);

    a_r7_no_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |=> !rsp_valid);

    a_r11_write_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we) |=> (rsp_rdata == 32'h0));

    a_r8_byte_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_size == 2'd0) |=> (rsp_rdata[31:8] == 24'h0));

    a_r9_half_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_size == 2'd1) |=> (rsp_rdata[31:16] == 16'h0));

    a_r6_ovf_after_reg: assert property (@(posedge clk) disable iff (!rst_n)
        reg_overflow |-> $past(reg_valid));

    a_r6_ovf_counts_hold: assert property (@(posedge clk) disable iff (!rst_n)
        reg_overflow |-> ($stable(m_cnt) && $stable(s_cnt)));

    a_r6_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (m_cnt <= FULL) && (s_cnt <= FULL));

    a_r2_master_step: assert property (@(posedge clk) disable iff (!rst_n)
        (m_cnt != $past(m_cnt)) |-> (m_cnt == $past(m_cnt) + 1'b1));

    a_r2_slave_step: assert property (@(posedge clk) disable iff (!rst_n)
        (s_cnt != $past(s_cnt)) |-> (s_cnt == $past(s_cnt) + 1'b1));

endmodule

bind pnp_desc_table pnp_desc_table_chk #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_valid    (reg_valid),
    .reg_overflow (reg_overflow),
    .bus_req      (bus_req),
    .bus_we       (bus_we),
    .bus_size     (bus_size),
    .rsp_valid    (rsp_valid),
    .rsp_rdata    (rsp_rdata),
    .m_cnt        (m_cnt),
    .s_cnt        (s_cnt)
);

// File: tb/sim_pnp_desc_table.sv
`timescale 1ns/1ps
module sim_pnp_desc_table;
    localparam int SLOTS = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_valid = 1'b0, reg_is_slave = 1'b0;
    logic [7:0]  reg_vendor = '0;
    logic [11:0] reg_device = '0, reg_mask = '0;
    logic [31:0] reg_addr = '0;
    logic [3:0]  reg_type = '0;
    logic        reg_overflow;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;

    int n_chk = 0, n_bad = 0;
    int nm = 0, ns = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pnp_desc_table #(.SLOTS(SLOTS)) u0 (.*);

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // registration values, computed per list and slot
    function automatic logic [7:0] f_ven(int sl, int i);
        return sl ? 8'(i * 11 + 8'h80) : 8'(i * 7 + 3);
    endfunction
    function automatic logic [11:0] f_dev(int sl, int i);
        return sl ? 12'(i * 53 + 12'h900) : 12'(i * 37 + 5);
    endfunction
    function automatic logic [31:0] f_adr(int sl, int i);
        return sl ? 32'h8000_0000 + 32'(i) * 32'h0010_0000 + 32'h000A_BCDE
                  : 32'h4000_0000 + 32'(i) * 32'h0010_0000 + 32'h0001_2345;
    endfunction
    function automatic logic [11:0] f_msk(int sl, int i);
        return sl ? 12'(12'hF00 ^ (i * 3)) : 12'(12'hFFF - i);
    endfunction
    function automatic logic [3:0] f_typ(int sl, int i);
        return sl ? 4'(i + 5) : 4'(i);
    endfunction

    function automatic logic [31:0] exp_word(int sl, int slot, int w);
        int cnt = sl ? ns : nm;
        logic [31:0] a;
        if (slot >= cnt) return 32'h0;
        a = f_adr(sl, slot);
        if (w == 0) return (32'(f_ven(sl, slot)) << 24) | (32'(f_dev(sl, slot)) << 12);
        if (w == 4) return (a & 32'hFFF0_0000) | (32'(f_msk(sl, slot)) << 4) | 32'(f_typ(sl, slot));
        return 32'h0;
    endfunction

    function automatic logic [11:0] waddr(int sl, int slot, int w);
        return 12'(sl * 12'h800 + slot * 32 + w * 4);
    endfunction

    task automatic do_reg(int sl, logic [7:0] v, logic [11:0] d, logic [31:0] a,
                          logic [11:0] m, logic [3:0] t, bit exp_ovf);
        @(negedge clk);
        reg_valid = 1'b1; reg_is_slave = 1'(sl);
        reg_vendor = v; reg_device = d; reg_addr = a; reg_mask = m; reg_type = t;
        @(negedge clk);
        reg_valid = 1'b0;
        check("R6 overflow flag", 32'(reg_overflow), 32'(exp_ovf));
    endtask

    task automatic reg_slot(int sl, int i);
        do_reg(sl, f_ven(sl, i), f_dev(sl, i), f_adr(sl, i), f_msk(sl, i), f_typ(sl, i), 1'b0);
        if (sl) ns++; else nm++;
    endtask

    task automatic do_acc(bit we, logic [11:0] a, logic [1:0] sz, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = 32'hDEAD_BEEF;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        check("R7 rsp_valid after request", 32'(rsp_valid), 32'd1);
        d = rsp_rdata;
    endtask

    task automatic sweep(string tag);
        logic [31:0] d;
        for (int sl = 0; sl < 2; sl++)
            for (int s = 0; s < SLOTS; s++)
                for (int w = 0; w < 8; w++) begin
                    do_acc(1'b0, waddr(sl, s, w), 2'd2, d);
                    check(tag, d, exp_word(sl, s, w));
                end
    endtask

    task automatic sub_reads(int sl, int s);
        logic [31:0] d, e;
        for (int w = 0; w < 8; w += 4) begin
            e = exp_word(sl, s, w);
            for (int b = 0; b < 4; b++) begin
                do_acc(1'b0, waddr(sl, s, w) + 12'(b), 2'd0, d);
                check("R8 byte lane", d, (e >> (8 * (3 - b))) & 32'hFF);
            end
            for (int h = 0; h < 2; h++) begin
                do_acc(1'b0, waddr(sl, s, w) + 12'(2 * h), 2'd1, d);
                check("R9 halfword lane", d, (e >> (16 * (1 - h))) & 32'hFFFF);
            end
            for (int o = 1; o < 4; o++) begin
                do_acc(1'b0, waddr(sl, s, w) + 12'(o), 2'(2 + (o & 1)), d);
                check("R10 word ignores low bits", d, e);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 overflow low after reset", 32'(reg_overflow), 32'd0);
        check("R7 rsp_valid low after reset", 32'(rsp_valid), 32'd0);
        sweep("R1 window zero after reset");

        for (int i = 0; i < 40; i++) reg_slot(0, i);
        for (int s = 38; s < 42; s++) begin
            do_acc(1'b0, waddr(0, s, 0), 2'd2, d);
            check("R2 partial master fill", d, exp_word(0, s, 0));
            do_acc(1'b0, waddr(0, s, 4), 2'd2, d);
            check("R5 unfilled slot zero", d, exp_word(0, s, 4));
        end
        for (int i = 0; i < SLOTS; i++) reg_slot(1, i);
        for (int i = 40; i < SLOTS; i++) reg_slot(0, i);

        do_reg(0, 8'hEE, 12'hEEE, 32'hFFFF_FFFF, 12'hEEE, 4'hE, 1'b1);
        @(negedge clk);
        check("R6 overflow is a single pulse", 32'(reg_overflow), 32'd0);
        do_reg(1, 8'hDD, 12'hDDD, 32'hFFFF_FFFF, 12'hDDD, 4'hD, 1'b1);
        do_reg(1, 8'hCC, 12'hCCC, 32'hFFFF_FFFF, 12'hCCC, 4'hC, 1'b1);
        @(negedge clk);
        check("R6 overflow clears", 32'(reg_overflow), 32'd0);

        sweep("R2 R3 R4 R5 full table");

        sub_reads(0, 0);  sub_reads(0, 17); sub_reads(0, 63);
        sub_reads(1, 0);  sub_reads(1, 42); sub_reads(1, 63);

        do_acc(1'b1, waddr(0, 5, 0), 2'd2, d);
        check("R11 write returns zero", d, 32'h0);
        do_acc(1'b1, waddr(0, 5, 1), 2'd2, d);
        check("R11 write returns zero", d, 32'h0);
        do_acc(1'b1, waddr(1, 0, 4) + 12'd1, 2'd0, d);
        check("R11 write returns zero", d, 32'h0);
        do_acc(1'b0, waddr(0, 5, 0), 2'd2, d);
        check("R11 word0 unchanged by write", d, exp_word(0, 5, 0));
        do_acc(1'b0, waddr(0, 5, 1), 2'd2, d);
        check("R11 word1 unchanged by write", d, 32'h0);
        do_acc(1'b0, waddr(1, 0, 4), 2'd2, d);
        check("R11 bank word unchanged by write", d, exp_word(1, 0, 4));
        @(negedge clk);
        check("R7 rsp_valid low when idle", 32'(rsp_valid), 32'd0);

        done = 1;
        summary();
    end

endmodule